// File: doc/BRIEF.md
# Packed 52-bit multiply-accumulate unit

This block is a SIMD integer datapath that views a 512-bit vector as up to eight 64-bit lanes. In every active lane it takes the low 52 bits of one source lane and the low 52 bits of another, multiplies them, and adds the low 52 bits of that product to a full 64-bit accumulator lane. The sum wraps modulo 2^64. The block is meant for big-number arithmetic kernels that carry limbs of 52 bits inside 64-bit words.

Each lane is steered by a lane mask. Masking can be turned on or off. A masked-off lane is either cleared or passes its accumulator through, depending on the masking mode. A broadcast option feeds the lowest element of the second source to every lane. A length select limits the operation to 2, 4 or 8 lanes, and every lane above that length is forced to zero.

One operation may be issued per cycle. The result comes out two cycles later through a two-stage pipeline.

Top module: `pmac_top`

## Requirements
- R1: Bits [63:52] of every lane of `srcA` and `srcB` have no effect on the result. Each multiplier operand is the lane's bits [51:0], zero-extended.
- R2: An active, unmasked lane gives `acc + zext64(low52(a[51:0] * b[51:0]))`, wrapped modulo 2^64. No carry or flag is produced.
- R3: `outValid` is high exactly two cycles after a cycle with `inValid` high, and low otherwise. A synchronous active-high `rst` clears both valid stages.
- R4: `vecLen` encodes the active lane count as 2'b00 = 2 lanes, 2'b01 = 4 lanes, and 2'b10 or 2'b11 = 8 lanes. Every result lane at or above that count is zero.
- R5: With `maskEn`=1, `zeroMode`=1 and `laneMask[i]`=0, lane i of the result is zero.
- R6: With `maskEn`=1, `zeroMode`=0 and `laneMask[i]`=0, an active lane i of the result equals lane i of `accIn` unchanged.
- R7: With `maskEn`=0, every active lane is computed whatever the value of `laneMask`.
- R8: With `bcastEn`=1, bits [51:0] of lane 0 of `srcB` form the second operand of every lane.
- R9: Operations issued on back-to-back cycles each produce their own correct result, in issue order, on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| inValid | input | 1 | Operation strobe; the operands are captured in this cycle |
| srcA | input | 512 | First multiplier source, eight 64-bit lanes |
| srcB | input | 512 | Second multiplier source, eight 64-bit lanes |
| accIn | input | 512 | Accumulator lanes |
| laneMask | input | 8 | One mask bit per lane, bit i for lane i |
| maskEn | input | 1 | 1 = the lane mask applies |
| zeroMode | input | 1 | 1 = masked-off lanes are cleared, 0 = they keep the accumulator |
| bcastEn | input | 1 | 1 = lane 0 of srcB feeds every lane |
| vecLen | input | 2 | Active lane count select (see R4) |
| outValid | output | 1 | Result strobe |
| result | output | 512 | Result lanes |

## Verification
The bench builds the unit with its default parameters: eight 64-bit lanes and 52-bit operands. With these values all three length codes, the whole 8-bit mask and the real 52/64 split are reachable. Two results can be computed by hand: all-ones operands give a low product of exactly 1, which makes an all-ones accumulator wrap to zero, and operands with set upper bits must act as their low 52 bits alone. The split of the operand into two 26-bit halves is covered both by these hand-checked cases and by scattered table values.

// File: rtl/pmac_pkg.sv
package pmac_pkg;

  localparam int unsigned LANES_DEF  = 8;
  localparam int unsigned LANE_W_DEF = 64;
  localparam int unsigned OPND_W_DEF = 52;

  // Per-lane output choice made by the control path.
  typedef enum logic [1:0] {
    SEL_SUM  = 2'd0,
    SEL_ACC  = 2'd1,
    SEL_ZERO = 2'd2
  } laneSel_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                           load1;
    logic                           load2;
    laneSel_t [LANES_DEF-1:0]       sel;
  } ctrlStrobes_t;

  // Active lane count for a length code, clipped to the lane count built.
  function automatic int unsigned laneCount(input logic [1:0] vl, input int unsigned maxL);
    int unsigned n;
    case (vl)
      2'b00:   n = 2;
      2'b01:   n = 4;
      default: n = 8;
    endcase
    return (n > maxL) ? maxL : n;
  endfunction

endpackage

// File: rtl/pmac_lane.sv
module pmac_lane
  import pmac_pkg::*;
#(
  parameter int unsigned LANE_W = LANE_W_DEF,
  parameter int unsigned OPND_W = OPND_W_DEF
) (
  input  logic              clk,
  input  logic              load1,
  input  logic              load2,
  input  laneSel_t          sel,
  input  logic [OPND_W-1:0] opA,
  input  logic [OPND_W-1:0] opB,
  input  logic [LANE_W-1:0] acc,
  output logic [LANE_W-1:0] res
);
  localparam int unsigned HALF = OPND_W / 2;

  logic [HALF-1:0]   aLo, aHi, bLo, bHi;
  logic [OPND_W-1:0] llNext, llQ;
  logic [HALF-1:0]   crossNext, crossQ;
  logic [LANE_W-1:0] accQ;
  logic [OPND_W-1:0] prodLo;
  logic [LANE_W-1:0] sumVal;
  logic [LANE_W-1:0] resQ;

  assign aLo = opA[HALF-1:0];
  assign aHi = opA[OPND_W-1:HALF];
  assign bLo = opB[HALF-1:0];
  assign bHi = opB[OPND_W-1:HALF];

  // Stage 1: only the partial products that reach the low half of the
  // product. High x high lands at bit OPND_W and above, so it is dropped.
  assign llNext    = OPND_W'(aLo) * OPND_W'(bLo);
  assign crossNext = aLo * bHi + aHi * bLo;

  always_ff @(posedge clk) begin
    if (load1) begin
      llQ    <= llNext;
      crossQ <= crossNext;
      accQ   <= acc;
    end
  end

  // Stage 2: fold the partial products, add the accumulator, apply the lane choice.
  assign prodLo = llQ + {crossQ, {HALF{1'b0}}};
  assign sumVal = accQ + LANE_W'(prodLo);

  always_ff @(posedge clk) begin
    if (load2) begin
      unique case (sel)
        SEL_SUM: resQ <= sumVal;
        SEL_ACC: resQ <= accQ;
        default: resQ <= '0;
      endcase
    end
  end

  assign res = resQ;

endmodule

// File: rtl/pmac_ctrl.sv
module pmac_ctrl
  import pmac_pkg::*;
#(
  parameter int unsigned LANES = LANES_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [LANES-1:0] laneMask,
  input  logic             maskEn,
  input  logic             zeroMode,
  input  logic [1:0]       vecLen,
  output ctrlStrobes_t     strobes,
  output logic             outValid
);
  logic     v1Q, v2Q;
  laneSel_t [LANES_DEF-1:0] selNext, selQ;
  int unsigned activeCnt;

  assign activeCnt = laneCount(vecLen, LANES);

  for (genvar i = 0; i < LANES_DEF; i++) begin : g_sel
    always_comb begin
      if (i >= LANES || i >= activeCnt)
        selNext[i] = SEL_ZERO;
      else if (!maskEn || laneMask[i % LANES])
        selNext[i] = SEL_SUM;
      else if (zeroMode)
        selNext[i] = SEL_ZERO;
      else
        selNext[i] = SEL_ACC;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1Q <= 1'b0;
      v2Q <= 1'b0;
    end else begin
      v1Q <= inValid;
      v2Q <= v1Q;
    end
  end

  always_ff @(posedge clk) begin
    if (inValid) selQ <= selNext;
  end

  assign strobes.load1 = inValid;
  assign strobes.load2 = v1Q;
  assign strobes.sel   = selQ;
  assign outValid      = v2Q;

  // R3: the valid flag moves one stage per cycle.
  assert_stage1_follows_R3: assert property (@(posedge clk) disable iff (rst)
    inValid |=> v1Q);
  assert_stage1_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !v1Q);
  assert_stage2_follows_R3: assert property (@(posedge clk) disable iff (rst)
    v1Q |=> outValid);
  assert_stage2_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !v1Q |=> !outValid);

endmodule

// File: rtl/pmac_datapath.sv
module pmac_datapath
  import pmac_pkg::*;
#(
  parameter int unsigned LANES  = LANES_DEF,
  parameter int unsigned LANE_W = LANE_W_DEF,
  parameter int unsigned OPND_W = OPND_W_DEF
) (
  input  logic                    clk,
  input  ctrlStrobes_t            strobes,
  input  logic [LANES*LANE_W-1:0] srcA,
  input  logic [LANES*LANE_W-1:0] srcB,
  input  logic [LANES*LANE_W-1:0] accIn,
  input  logic                    bcastEn,
  output logic [LANES*LANE_W-1:0] result
);
  // The operand bits above OPND_W never reach a multiplier.
  logic unusedSrcBits;
  assign unusedSrcBits = ^{srcA, srcB};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [OPND_W-1:0] opBSel;
    assign opBSel = bcastEn ? srcB[OPND_W-1:0] : srcB[i*LANE_W +: OPND_W];

    pmac_lane #(.LANE_W(LANE_W), .OPND_W(OPND_W)) u_lane (
      .clk   (clk),
      .load1 (strobes.load1),
      .load2 (strobes.load2),
      .sel   (strobes.sel[i]),
      .opA   (srcA[i*LANE_W +: OPND_W]),
      .opB   (opBSel),
      .acc   (accIn[i*LANE_W +: LANE_W]),
      .res   (result[i*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/pmac_top.sv
module pmac_top
  import pmac_pkg::*;
#(
  parameter int unsigned LANES  = LANES_DEF,
  parameter int unsigned LANE_W = LANE_W_DEF,
  parameter int unsigned OPND_W = OPND_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic [LANES*LANE_W-1:0] srcA,
  input  logic [LANES*LANE_W-1:0] srcB,
  input  logic [LANES*LANE_W-1:0] accIn,
  input  logic [LANES-1:0]        laneMask,
  input  logic                    maskEn,
  input  logic                    zeroMode,
  input  logic                    bcastEn,
  input  logic [1:0]              vecLen,
  output logic                    outValid,
  output logic [LANES*LANE_W-1:0] result
);
  ctrlStrobes_t strobes;

  pmac_ctrl #(.LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .laneMask (laneMask),
    .maskEn   (maskEn),
    .zeroMode (zeroMode),
    .vecLen   (vecLen),
    .strobes  (strobes),
    .outValid (outValid)
  );

  pmac_datapath #(.LANES(LANES), .LANE_W(LANE_W), .OPND_W(OPND_W)) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .srcA    (srcA),
    .srcB    (srcB),
    .accIn   (accIn),
    .bcastEn (bcastEn),
    .result  (result)
  );

  // Port-level checks per lane, relating the result to the inputs of two cycles before.
  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assert_lane_beyond_len_R4: assert property (@(posedge clk) disable iff (rst)
      (outValid && (i >= laneCount($past(vecLen, 2), LANES)))
        |-> (result[i*LANE_W +: LANE_W] == '0));
    assert_masked_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (outValid && $past(maskEn, 2) && $past(zeroMode, 2) && !$past(laneMask[i], 2))
        |-> (result[i*LANE_W +: LANE_W] == '0));
    assert_masked_merge_R6: assert property (@(posedge clk) disable iff (rst)
      (outValid && $past(maskEn, 2) && !$past(zeroMode, 2) && !$past(laneMask[i], 2)
        && (i < laneCount($past(vecLen, 2), LANES)))
        |-> (result[i*LANE_W +: LANE_W] == $past(accIn[i*LANE_W +: LANE_W], 2)));
  end

endmodule

// File: tb/tb_pmac_top.sv
module tb_pmac_top;

  localparam int LANES  = 8;
  localparam int LANE_W = 64;
  localparam int VEC_W  = LANES * LANE_W;

  typedef struct packed {
    logic [63:0] aSeed;
    logic [63:0] bSeed;
    logic [63:0] accSeed;
    logic [7:0]  mask;
    logic        maskEn;
    logic        zeroMode;
    logic        bcast;
    logic [1:0]  vlen;
    logic [15:0] tag;
  } row_t;

  localparam int NROWS = 10;
  localparam row_t ROWS [NROWS] = '{
    '{64'h0000_1234_5678_9ABC, 64'h0000_0FED_CBA9_8765, 64'h0000_0000_0000_0011, 8'h00, 1'b0, 1'b0, 1'b0, 2'b10, "R2"},
    '{64'h000F_FFFF_0000_0001, 64'h0003_0000_FFFF_0003, 64'h1111_2222_3333_4444, 8'hFF, 1'b0, 1'b0, 1'b0, 2'b00, "R4"},
    '{64'h0008_0000_0000_0000, 64'h0008_0000_0000_0001, 64'hFFFF_FFFF_FFFF_0000, 8'hFF, 1'b0, 1'b0, 1'b0, 2'b01, "R4"},
    '{64'h0000_0000_0400_0000, 64'h000A_BCDE_F012_3456, 64'h0123_0000_0000_0000, 8'h00, 1'b0, 1'b0, 1'b0, 2'b11, "R4"},
    '{64'h0007_7777_7777_7777, 64'h0005_5555_5555_5555, 64'hAAAA_0000_5555_0000, 8'hA5, 1'b1, 1'b0, 1'b0, 2'b10, "R6"},
    '{64'h0002_4680_1357_9BDF, 64'h000E_0000_0001_FFFF, 64'h0F0F_0F0F_0F0F_0F0F, 8'h3C, 1'b1, 1'b1, 1'b0, 2'b10, "R5"},
    '{64'h0001_0000_0000_0001, 64'h0001_0000_0000_0001, 64'h8000_0000_0000_0000, 8'h00, 1'b0, 1'b1, 1'b0, 2'b10, "R7"},
    '{64'h0000_ABCD_EF01_2345, 64'h0009_8765_4321_0FED, 64'h0000_0000_0000_0000, 8'h00, 1'b0, 1'b0, 1'b1, 2'b10, "R8"},
    '{64'h0003_3333_3333_3333, 64'h0004_4444_4444_4444, 64'h7777_0000_0000_7777, 8'h06, 1'b1, 1'b0, 1'b1, 2'b01, "R8"},
    '{64'hFFF5_5555_5555_5555, 64'hABC3_3333_3333_3333, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 1'b0, 1'b0, 1'b0, 2'b10, "R1"}
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             inValid;
  logic [VEC_W-1:0] srcA, srcB, accIn;
  logic [7:0]       laneMask;
  logic             maskEn, zeroMode, bcastEn;
  logic [1:0]       vecLen;
  logic             outValid;
  logic [VEC_W-1:0] result;

  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pmac_top dut (
    .clk(clk), .rst(rst), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .accIn(accIn), .laneMask(laneMask), .maskEn(maskEn), .zeroMode(zeroMode),
    .bcastEn(bcastEn), .vecLen(vecLen), .outValid(outValid), .result(result)
  );

  // Reference for one lane, in 128-bit arithmetic.
  function automatic logic [63:0] refLane(logic [63:0] a, logic [63:0] b, logic [63:0] acc);
    logic [127:0] p;
    p = {76'b0, a[51:0]} * {76'b0, b[51:0]};
    return acc + {12'b0, p[51:0]};
  endfunction

  function automatic logic [VEC_W-1:0] refVec(logic [VEC_W-1:0] a, logic [VEC_W-1:0] b,
      logic [VEC_W-1:0] acc, logic [7:0] m, logic men, logic zm, logic bc, logic [1:0] vl);
    logic [VEC_W-1:0] r;
    int n;
    n = (vl == 2'b00) ? 2 : (vl == 2'b01) ? 4 : 8;
    for (int i = 0; i < LANES; i++) begin
      logic [63:0] bl;
      bl = bc ? b[63:0] : b[i*64 +: 64];
      if (i >= n)                r[i*64 +: 64] = '0;
      else if (men && !m[i])     r[i*64 +: 64] = zm ? 64'h0 : acc[i*64 +: 64];
      else                       r[i*64 +: 64] = refLane(a[i*64 +: 64], bl, acc[i*64 +: 64]);
    end
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] spread(logic [63:0] seed);
    logic [VEC_W-1:0] v;
    for (int i = 0; i < LANES; i++)
      v[i*64 +: 64] = seed + 64'(i) * 64'h0000_0C3A_5B1D_9E27;
    return v;
  endfunction

  task automatic checkBit(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s outValid got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic checkVec(string tag, logic [VEC_W-1:0] exp);
    checks++;
    if (outValid !== 1'b1 || result !== exp) begin
      bad++;
      $display("FAIL %s outValid=%0b result got=%h exp=%h", tag, outValid, result, exp);
    end
  endtask

  task automatic drive(logic [VEC_W-1:0] a, logic [VEC_W-1:0] b, logic [VEC_W-1:0] acc,
      logic [7:0] m, logic men, logic zm, logic bc, logic [1:0] vl);
    srcA = a; srcB = b; accIn = acc; laneMask = m;
    maskEn = men; zeroMode = zm; bcastEn = bc; vecLen = vl;
  endtask

  // Issue one operation at a falling edge and check it two cycles later.
  task automatic runOne(string tag, logic [VEC_W-1:0] a, logic [VEC_W-1:0] b,
      logic [VEC_W-1:0] acc, logic [7:0] m, logic men, logic zm, logic bc,
      logic [1:0] vl, logic [VEC_W-1:0] exp);
    @(negedge clk);
    drive(a, b, acc, m, men, zm, bc, vl);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    checkVec(tag, exp);
  endtask

  initial begin
    logic [VEC_W-1:0] expS [4];
    logic [VEC_W-1:0] aS [4];
    logic [VEC_W-1:0] bS [4];
    logic [VEC_W-1:0] cS [4];
    rst = 1'b1; inValid = 1'b0;
    drive('0, '0, '0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b10);
    repeat (3) @(negedge clk);
    checkBit("R3 reset", outValid, 1'b0);
    rst = 1'b0;

    // Table of stimulus rows, each checked against the reference model.
    for (int r = 0; r < NROWS; r++) begin
      logic [VEC_W-1:0] a, b, c;
      string t;
      a = spread(ROWS[r].aSeed);
      b = spread(ROWS[r].bSeed);
      c = spread(ROWS[r].accSeed);
      t = string'(ROWS[r].tag);
      runOne(t, a, b, c, ROWS[r].mask, ROWS[r].maskEn, ROWS[r].zeroMode,
             ROWS[r].bcast, ROWS[r].vlen,
             refVec(a, b, c, ROWS[r].mask, ROWS[r].maskEn, ROWS[r].zeroMode,
                    ROWS[r].bcast, ROWS[r].vlen));
    end

    // R2: all-ones operands give a low product of 1; all-ones accumulator wraps to 0.
    runOne("R2 wrap", {VEC_W{1'b1}}, {VEC_W{1'b1}}, {VEC_W{1'b1}},
           8'h00, 1'b0, 1'b0, 1'b0, 2'b10, {VEC_W{1'b0}});

    // R1: upper operand bits set; 3*5=15 added to 2^64-11 wraps to 4 per lane.
    runOne("R1 upper", {LANES{64'hFFF0_0000_0000_0003}}, {LANES{64'hABC0_0000_0000_0005}},
           {LANES{64'hFFFF_FFFF_FFFF_FFF5}}, 8'h00, 1'b0, 1'b0, 1'b0, 2'b10,
           {LANES{64'h0000_0000_0000_0004}});

    // R3: valid appears only in the second cycle after issue.
    @(negedge clk);
    drive(spread(64'h5), spread(64'h7), spread(64'h9), 8'h00, 1'b0, 1'b0, 1'b0, 2'b10);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkBit("R3 after one cycle", outValid, 1'b0);
    @(negedge clk);
    checkBit("R3 after two cycles", outValid, 1'b1);
    @(negedge clk);
    checkBit("R3 after three cycles", outValid, 1'b0);

    // R9: four back-to-back issues with differing modes.
    for (int k = 0; k < 4; k++) begin
      aS[k] = spread(64'h0004_0000_1000_0001 * 64'(k + 3));
      bS[k] = spread(64'h000B_0300_0000_0707 + 64'(k));
      cS[k] = spread(64'hFFFF_FFFF_0000_0000 + 64'(k * 17));
    end
    expS[0] = refVec(aS[0], bS[0], cS[0], 8'h0F, 1'b1, 1'b0, 1'b0, 2'b10);
    expS[1] = refVec(aS[1], bS[1], cS[1], 8'hF0, 1'b1, 1'b1, 1'b0, 2'b10);
    expS[2] = refVec(aS[2], bS[2], cS[2], 8'h00, 1'b0, 1'b0, 1'b1, 2'b01);
    expS[3] = refVec(aS[3], bS[3], cS[3], 8'h55, 1'b0, 1'b0, 1'b0, 2'b00);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k >= 2) checkVec("R9 stream", expS[k-2]);
      case (k)
        0: drive(aS[0], bS[0], cS[0], 8'h0F, 1'b1, 1'b0, 1'b0, 2'b10);
        1: drive(aS[1], bS[1], cS[1], 8'hF0, 1'b1, 1'b1, 1'b0, 2'b10);
        2: drive(aS[2], bS[2], cS[2], 8'h00, 1'b0, 1'b0, 1'b1, 2'b01);
        3: drive(aS[3], bS[3], cS[3], 8'h55, 1'b0, 1'b0, 1'b0, 2'b00);
        default: ;
      endcase
      inValid = (k < 4);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL R3 watchdog got=running exp=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule